// File: doc/BRIEF.md
# Host Bus Error Capture Register

This block is one 32-bit status register. It watches host bus transactions after they have been translated to internal addresses. While no error is pending, its address field follows the internal address of every transaction it sees. The first transaction that ends in an internal bus error, with reporting enabled, raises a sticky error flag. From then on the field holds that address, so firmware can find the faulting access. Host DMA accesses that fail also set a second, separate sticky flag. Firmware clears both flags by writing ones to their bit positions.

The block also turns an active-low power-down input pin into an active-high status output. The pin passes through a two-flop synchronizer first. Firmware reads the register combinationally through `reg_rdata` and writes it with a single-cycle `reg_wr` strobe.

Top module: `hbe_capture`

## Requirements
- R1: After the active-low reset `rst_n`, `reg_rdata` reads 0 and `pd_status` is 0.
- R2: While the error flag (bit 0) is 0, each clock edge with `obs_valid` high loads `obs_addr` into bits 31:8. The new value is visible after that edge.
- R3: An edge with `obs_valid` and `obs_err` high while the enable (bit 1) is 1 sets bit 0. If bit 0 was 0 before that edge, the same edge captures the faulting address in bits 31:8.
- R4: While bit 0 is 1, bits 31:8 keep their value whatever transactions arrive.
- R5: With bit 1 at 0, an error transaction sets neither bit 0 nor bit 5, and the address keeps tracking as in R2.
- R6: An edge with `obs_valid`, `obs_err` and `obs_dma` all high while bit 1 is 1 sets bit 5.
- R7: Bits 0 and 5 stay set until a write with a 1 in that bit position. Writing 0 there has no effect.
- R8: When a flag is set and cleared by a write on the same edge, the set wins and the flag reads 1 afterwards.
- R9: Bit 1 is a plain read/write bit. Bits 7:6 and 4:2 read 0. Writes to bits 31:8 are ignored.
- R10: `pd_status` equals the inverse of `pd_n`, delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obs_valid | input | 1 | A host transaction completes this cycle |
| obs_addr | input | 24 | Internal address of the transaction |
| obs_dma | input | 1 | The transaction is a DMA access |
| obs_err | input | 1 | The transaction ended in an internal bus error |
| reg_wr | input | 1 | Firmware write strobe |
| reg_wdata | input | 32 | Firmware write data |
| reg_rdata | output | 32 | Register read value |
| pd_n | input | 1 | Active-low power-down pin, asynchronous |
| pd_status | output | 1 | Synchronized, active-high power-down status |

## Verification
Plain transactions with no error show that the address tracks every access. An enabled non-DMA error followed by later transactions shows that the address freezes and that bit 5 stays clear. A DMA error while the address is frozen separates the DMA flag from the address capture. Error transactions that land in the same cycle as a write-one-to-clear show which one wins, both with the flag previously clear and with it already set. Errors with reporting disabled show that the enable gates both flags but does not stop address tracking. A behavioural model compared on every clock covers all the cycles in between.

// File: rtl/hbe_capture.sv
module hbe_capture #(
  parameter int ADDR_W  = 24,
  parameter int REG_W   = 32,
  parameter int BIT_ERR = 0,
  parameter int BIT_EN  = 1,
  parameter int BIT_DMA = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obs_valid,
  input  logic [ADDR_W-1:0] obs_addr,
  input  logic              obs_dma,
  input  logic              obs_err,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              pd_n,
  output logic              pd_status
);
  localparam int ALO = REG_W - ADDR_W;

  logic [ADDR_W-1:0] cap_addr;
  logic              err_flag, dma_flag, en_bit;
  logic [1:0]        pd_sync;

  wire hit_err = obs_valid && obs_err && en_bit;
  wire hit_dma = hit_err && obs_dma;
  wire clr_err = reg_wr && reg_wdata[BIT_ERR];
  wire clr_dma = reg_wr && reg_wdata[BIT_DMA];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0;
      err_flag <= 1'b0;
      dma_flag <= 1'b0;
      en_bit   <= 1'b0;
      pd_sync  <= 2'b11;
    end else begin
      if (obs_valid && !err_flag) cap_addr <= obs_addr;
      if (hit_err)      err_flag <= 1'b1;
      else if (clr_err) err_flag <= 1'b0;
      if (hit_dma)      dma_flag <= 1'b1;
      else if (clr_dma) dma_flag <= 1'b0;
      if (reg_wr) en_bit <= reg_wdata[BIT_EN];
      pd_sync <= {pd_sync[0], pd_n};
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[REG_W-1:ALO] = cap_addr;
    reg_rdata[BIT_DMA] = dma_flag;
    reg_rdata[BIT_EN]  = en_bit;
    reg_rdata[BIT_ERR] = err_flag;
  end

  assign pd_status = ~pd_sync[1];

  p_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_valid && !reg_rdata[BIT_ERR]) |=> reg_rdata[REG_W-1:ALO] == $past(obs_addr));
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_valid && obs_err && reg_rdata[BIT_EN]) |=> reg_rdata[BIT_ERR]);
  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[BIT_ERR] |=> $stable(reg_rdata[REG_W-1:ALO]));
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[BIT_EN] && !reg_rdata[BIT_DMA]) |=> !reg_rdata[BIT_DMA]);
  p_dma_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_valid && obs_err && obs_dma && reg_rdata[BIT_EN]) |=> reg_rdata[BIT_DMA]);
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[BIT_ERR] && !(obs_valid && obs_err && reg_rdata[BIT_EN]))
      |=> !reg_rdata[BIT_ERR]);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[BIT_DMA] && !(reg_wr && reg_wdata[BIT_DMA])) |=> reg_rdata[BIT_DMA]);
  p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:6] == 2'b00 && reg_rdata[4:2] == 3'b000);
endmodule

// File: tb/hbe_capture_bench.sv
module hbe_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        obs_valid = 1'b0, obs_dma = 1'b0, obs_err = 1'b0;
  logic [23:0] obs_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pd_n = 1'b1;
  logic        pd_status;

  int checks = 0, failures = 0;

  hbe_capture u_hbe_capture (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_addr(obs_addr),
    .obs_dma(obs_dma), .obs_err(obs_err), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pd_n(pd_n), .pd_status(pd_status)
  );

  always #2 clk = ~clk;

  int m_addr, m_int, m_dma, m_en;
  bit pd_hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_int = 0; m_dma = 0; m_en = 0;
      pd_hist = '{1'b1, 1'b1};
    end else begin
      bit s_err, s_dma;
      s_err = obs_valid && obs_err && (m_en != 0);
      s_dma = s_err && obs_dma;
      if (obs_valid && m_int == 0) m_addr = int'(obs_addr);
      if (s_err) m_int = 1; else if (reg_wr && reg_wdata[0]) m_int = 0;
      if (s_dma) m_dma = 1; else if (reg_wr && reg_wdata[5]) m_dma = 0;
      if (reg_wr) m_en = int'(reg_wdata[1]);
      pd_hist.push_back(pd_n);
      void'(pd_hist.pop_front());
    end
  end

  function automatic logic [31:0] model_word();
    return (m_addr << 8) | (m_dma << 5) | (m_en << 1) | m_int;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(reg_rdata === model_word(), "MODEL R2", reg_rdata, model_word());
    chk(pd_status === !pd_hist[0], "MODEL R10", {31'd0, pd_status}, {31'd0, !pd_hist[0]});
  end

  task automatic cyc(bit v, logic [23:0] a, bit d, bit e, bit w, logic [31:0] wd);
    obs_valid = v; obs_addr = a; obs_dma = d; obs_err = e;
    reg_wr = w; reg_wdata = wd;
    @(negedge clk);
    obs_valid = 0; obs_err = 0; obs_dma = 0; reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic expect_reg(logic [31:0] exp, string req);
    chk(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_reg(32'h0, "R1 rdata");
    chk(pd_status === 1'b0, "R1 pd_status", {31'd0, pd_status}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_reg(32'h0, "R1 after release");

    cyc(1, 24'h123456, 0, 0, 0, 0);
    expect_reg(32'h12345600, "R2 track");
    cyc(1, 24'hABCDEF, 0, 1, 0, 0);
    expect_reg(32'hABCDEF00, "R5 err ignored when disabled");

    cyc(0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    expect_reg(32'hABCDEF02, "R9 write all ones");

    cyc(1, 24'h000111, 0, 1, 0, 0);
    expect_reg(32'h00011103, "R3 capture");
    cyc(1, 24'h222222, 0, 0, 0, 0);
    expect_reg(32'h00011103, "R4 frozen");
    cyc(1, 24'h333333, 1, 1, 0, 0);
    expect_reg(32'h00011123, "R6 dma flag");

    cyc(0, 0, 0, 0, 1, 32'h0000_0002);
    expect_reg(32'h00011123, "R7 write zero");
    cyc(0, 0, 0, 0, 1, 32'h0000_0003);
    expect_reg(32'h00011122, "R7 clear err");
    cyc(1, 24'h444444, 0, 0, 0, 0);
    expect_reg(32'h44444422, "R2 tracking resumes");
    cyc(0, 0, 0, 0, 1, 32'h0000_0022);
    expect_reg(32'h44444402, "R7 clear dma");

    cyc(1, 24'h555555, 1, 1, 1, 32'h0000_0023);
    expect_reg(32'h55555523, "R8 set wins flag clear");
    cyc(1, 24'h666666, 1, 1, 1, 32'h0000_0023);
    expect_reg(32'h55555523, "R8 set wins flag set");

    cyc(0, 0, 0, 0, 1, 32'h0000_0021);
    expect_reg(32'h55555500, "R9 disable");
    cyc(1, 24'h777777, 1, 1, 0, 0);
    expect_reg(32'h77777700, "R5 disabled dma err");

    pd_n = 1'b0;
    @(negedge clk);
    chk(pd_status === 1'b0, "R10 one edge", {31'd0, pd_status}, 32'd0);
    @(negedge clk);
    chk(pd_status === 1'b1, "R10 two edges", {31'd0, pd_status}, 32'd1);
    pd_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pd_status === 1'b0, "R10 release", {31'd0, pd_status}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule